// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog for a system-on-chip. A down-counter is clocked by a slow tick that the system presents as a clock enable, so the whole block runs in the system clock domain. When the counter runs out, the block raises a one-cycle reset-request pulse, reloads itself and counts on. Software reaches the block over a simple 32-bit register bus.

Magic values written to the key register do three jobs. One value opens the configuration registers to writes. One starts the watchdog. One refreshes the counter. The divider code, the reload value and the window limit can be changed only while the configuration is open. A new divider or reload value reaches the counter side only after a fixed number of slow ticks, which models the crossing into the slow domain. Two status flags show that such an update is still on its way.

A window limit adds an optional check for refreshes that come too early. If software refreshes while the counter is still above the window value, the block treats this as a fault and requests a reset at once.

Top module: `kwdt_top`

## Requirements
- R1: After reset the divider code (offset 0x04) reads 0, the reload value (offset 0x08) reads 0xFFF, the window value (offset 0x10) reads 0xFFF, status (offset 0x0C) reads 0, the counter is stopped and `wdt_req` is low.
- R2: Writing the key 0x00005555 to offset 0x00 opens the configuration. While it is open, writes take effect and read back: the divider code at offset 0x04 bits 2:0, the reload value at offset 0x08 bits 11:0 and the window value at offset 0x10 bits 11:0.
- R3: While the configuration is closed, writes to offsets 0x04, 0x08 and 0x10 are ignored and set no status flag. Writing the key 0x00000000, or any key value that is not defined, closes the configuration. The keys 0x0000CCCC and 0x0000AAAA leave the open or closed state as it is.
- R4: Status bit 0 (divider update) and status bit 1 (reload update) are set in the cycle after an accepted write to their register. Each bit clears after exactly 2 slow ticks (SYNC_TICKS). It stays set for as long as no tick arrives.
- R5: The counter side keeps using the old divider or reload value until that value's status flag has cleared.
- R6: The key 0x0000CCCC starts the watchdog. A timeout comes (reload + 1) × divider slow ticks after the start. The divider is 4 << code for codes 0 to 6, and code 7 also gives 256. At the timeout `wdt_req` is high for exactly one cycle.
- R7: After a timeout the counter reloads and runs on, so the timeouts repeat with the same period.
- R8: The key 0x0000AAAA reloads the counter and restarts the divider, so the next timeout comes one full period after the refresh.
- R9: Once the watchdog is running, no key write stops it. Only `rst_n` stops it.
- R10: A refresh while the watchdog is running and the counter is above the window value raises `wdt_req` in the next cycle and reloads the counter. A refresh at or below the window value raises no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow-clock enable; one slow tick per cycle in which it is high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of `bus_addr` |
| wdt_req | output | 1 | One-cycle reset-request pulse |

## Verification
A register write takes effect at the clock edge on which it is sampled, and its readback and status flag can be seen half a cycle later. A pending flag drops two tick-carrying edges after the write. A timeout pulse is counted from the edge that took the start or refresh key: `wdt_req` goes high after edge (reload + 1) × divider when the tick is held high, and an early refresh shows its pulse right after the refresh edge. The bench drives and samples at the falling edge, so it counts whole cycles from the write edge and compares each pulse position with that number exactly. It also checks that no pulse appears at any earlier sample.

// File: rtl/kwdt_pkg.sv
// Shared constants for the keyed watchdog: key values, register offsets
// and the command that a key write hands to the counter side.
package kwdt_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [31:0] KEY_OPEN = 32'h0000_5555;
    localparam logic [31:0] KEY_SHUT = 32'h0000_0000;
    localparam logic [31:0] KEY_RUN  = 32'h0000_CCCC;
    localparam logic [31:0] KEY_KICK = 32'h0000_AAAA;

    localparam int unsigned OFS_KEY  = 32'h00;
    localparam int unsigned OFS_DIV  = 32'h04;
    localparam int unsigned OFS_RLD  = 32'h08;
    localparam int unsigned OFS_STAT = 32'h0C;
    localparam int unsigned OFS_WIN  = 32'h10;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RUN  = 2'd1,
        CMD_KICK = 2'd2
    } key_cmd_e;
endpackage

// File: rtl/kwdt_regs.sv
// Bus-side register file. Decodes the key register, keeps the write lock,
// stores divider code, reload and window values, and reads them back.
// Assumes single-cycle writes and a combinational read mux.
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 12,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              pend_div,
    input  logic              pend_rld,
    output logic [31:0]       bus_rdata,
    output logic [PSC_W-1:0]  div_code_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic [CNT_W-1:0]  win_q,
    output logic              div_wr,
    output logic              rld_wr,
    output key_cmd_e          cmd
);
    timeunit 1ns;
    timeprecision 100ps;

    logic unlocked_q;
    logic is_key, is_div, is_rld, is_win, is_stat, win_wr;

    // address decode
    always_comb begin
        is_key  = (bus_addr == ADDR_W'(OFS_KEY));
        is_div  = (bus_addr == ADDR_W'(OFS_DIV));
        is_rld  = (bus_addr == ADDR_W'(OFS_RLD));
        is_stat = (bus_addr == ADDR_W'(OFS_STAT));
        is_win  = (bus_addr == ADDR_W'(OFS_WIN));
    end

    assign div_wr = bus_wr && is_div && unlocked_q;
    assign rld_wr = bus_wr && is_rld && unlocked_q;
    assign win_wr = bus_wr && is_win && unlocked_q;

    // write lock: opened by one key, closed by the close key or any unknown key
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked_q <= 1'b0;
        else if (bus_wr && is_key) begin
            if (bus_wdata == KEY_OPEN)
                unlocked_q <= 1'b1;
            else if (bus_wdata != KEY_RUN && bus_wdata != KEY_KICK)
                unlocked_q <= 1'b0;
        end
    end

    // configuration storage, written only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code_q <= '0;
            rld_q      <= '1;
            win_q      <= '1;
        end else begin
            if (div_wr) div_code_q <= bus_wdata[PSC_W-1:0];
            if (rld_wr) rld_q      <= bus_wdata[CNT_W-1:0];
            if (win_wr) win_q      <= bus_wdata[CNT_W-1:0];
        end
    end

    // start and refresh commands for the counter side
    always_comb begin
        cmd = CMD_NONE;
        if (bus_wr && is_key) begin
            if (bus_wdata == KEY_RUN)       cmd = CMD_RUN;
            else if (bus_wdata == KEY_KICK) cmd = CMD_KICK;
        end
    end

    // read mux; the key register reads as zero
    always_comb begin
        bus_rdata = '0;
        if (is_div)       bus_rdata = 32'(div_code_q);
        else if (is_rld)  bus_rdata = 32'(rld_q);
        else if (is_win)  bus_rdata = 32'(win_q);
        else if (is_stat) bus_rdata = {30'd0, pend_rld, pend_div};
    end

    // R3: a write to the reload register while locked leaves it unchanged
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_rld && !unlocked_q) |=> $stable(rld_q));

    // R2: the open key always unlocks
    assert_open_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_key && bus_wdata == KEY_OPEN) |=> unlocked_q);
endmodule

// File: rtl/kwdt_xfer.sv
// Delayed transfer of one configuration value to the counter side.
// A write raises the pending flag. After SYNC_TICKS slow ticks the value is
// copied into the counter-side shadow and the flag drops. A new write
// restarts the delay. Assumes SYNC_TICKS >= 1.
module kwdt_xfer #(
    parameter int          W          = 12,
    parameter int          SYNC_TICKS = 2,
    parameter logic [W-1:0] RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] src,
    output logic         pend,
    output logic [W-1:0] dst
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CW = $clog2(SYNC_TICKS + 1);

    logic [CW-1:0] left_q;

    // tick countdown of the transfer delay
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (load)
            left_q <= CW'(SYNC_TICKS);
        else if (tick && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    // shadow copy, updated on the final tick of the delay
    always_ff @(posedge clk) begin
        if (!rst_n)
            dst <= RST_VAL;
        else if (!load && tick && left_q == CW'(1))
            dst <= src;
    end

    assign pend = (left_q != '0);

    // R4: an accepted write shows as pending in the next cycle
    assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pend);

    // R4: without a tick the pending flag holds
    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !tick) |=> pend);

    // R5: the shadow never moves while nothing is pending
    assert_shadow_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(dst));
endmodule

// File: rtl/kwdt_core.sv
// Counter side: prescaler divider and down-counter. Starts on the run
// command and then runs until reset. Refreshes on the kick command and
// pulses the reset request on timeout or on a refresh above the window.
// Assumes one slow tick per cycle in which tick is high.
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  key_cmd_e         cmd,
    input  logic [PSC_W-1:0] div_code,
    input  logic [CNT_W-1:0] rld,
    input  logic [CNT_W-1:0] win,
    output logic             wdt_req
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MAX_SHIFT = 1 << PSC_W;
    localparam int DIV_W     = MAX_SHIFT;

    logic             running_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] lim;
    logic             start, kick, early, step, expire;
    int               shift;

    // divider terminal count: 4 << code, clamped at the widest divider
    always_comb begin
        shift = int'(div_code) + 2;
        if (shift > MAX_SHIFT) shift = MAX_SHIFT;
        lim = DIV_W'((32'd1 << shift) - 32'd1);
    end

    assign start  = (cmd == CMD_RUN) && !running_q;
    assign kick   = (cmd == CMD_KICK);
    assign early  = kick && running_q && (cnt_q > win);
    assign step   = running_q && tick && (pre_q >= lim);
    assign expire = step && (cnt_q == '0);

    // run flag: set once and cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            running_q <= 1'b0;
        else if (start)
            running_q <= 1'b1;
    end

    // prescaler and down-counter, reloaded on start, refresh or timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            pre_q <= '0;
        end else if (start || kick || expire) begin
            cnt_q <= rld;
            pre_q <= '0;
        end else if (running_q && tick) begin
            if (pre_q >= lim) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // registered one-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdt_req <= 1'b0;
        else
            wdt_req <= expire || early;
    end

    // R9: once running, always running
    assert_stay_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> running_q);

    // R6: a reset request is raised only by a running watchdog
    assert_req_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |-> running_q);

    // R7: after a timeout the counter holds the reload value
    assert_reload_after_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !kick) |=> (cnt_q == $past(rld)));

    // R10: an early refresh is followed by a request
    assert_early_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> wdt_req);
endmodule

// File: rtl/kwdt_top.sv
// Keyed independent watchdog: register file, two delayed configuration
// transfers (divider code and reload) and the counting core.
// The slow clock arrives as the tick enable, so there is a single domain.
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int CNT_W      = 12,
    parameter int PSC_W      = 3,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_req
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [PSC_W-1:0] div_code_q, div_code_sh;
    logic [CNT_W-1:0] rld_q, rld_sh, win_q;
    logic             div_wr, rld_wr, pend_div, pend_rld;
    key_cmd_e         cmd;

    kwdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pend_div(pend_div), .pend_rld(pend_rld),
        .bus_rdata(bus_rdata), .div_code_q(div_code_q), .rld_q(rld_q),
        .win_q(win_q), .div_wr(div_wr), .rld_wr(rld_wr), .cmd(cmd)
    );

    kwdt_xfer #(.W(PSC_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_div_xfer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(div_wr),
        .src(div_code_q), .pend(pend_div), .dst(div_code_sh)
    );

    kwdt_xfer #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) u_rld_xfer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(rld_wr),
        .src(rld_q), .pend(pend_rld), .dst(rld_sh)
    );

    kwdt_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd),
        .div_code(div_code_sh), .rld(rld_sh), .win(win_q), .wdt_req(wdt_req)
    );
endmodule

// File: tb/tb_kwdt_top.sv
// Directed bench for kwdt_top: one task per scenario, drive and sample on
// the falling edge, expected cycle counts computed from the requirements.
module tb_kwdt_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [31:0] K_OPEN = 32'h5555, K_SHUT = 32'h0000;
    localparam logic [31:0] K_RUN  = 32'hCCCC, K_KICK = 32'hAAAA;
    localparam logic [4:0]  A_KEY = 5'h00, A_DIV = 5'h04, A_RLD = 5'h08;
    localparam logic [4:0]  A_STAT = 5'h0C, A_WIN = 5'h10;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b1, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        wdt_req;
    int          total = 0, bad = 0, cyc = 0;
    bit          done = 1'b0;

    kwdt_top dut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                  .bus_rdata(bus_rdata), .wdt_req(wdt_req));

    always #2.5 clk = ~clk;

    // watchdog for the run itself
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; tick = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // cycles from the last write edge until the first pulse sample
    task automatic wait_pulse(output int n);
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (wdt_req) break;
        end
    endtask

    task automatic configure(input int code, input int rl);
        wr(A_KEY, K_OPEN);
        wr(A_DIV, 32'(code));
        wr(A_RLD, 32'(rl));
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        int v;
        do_reset();
        rd(A_DIV, v);  chk("R1 divider code", v, 0);
        rd(A_RLD, v);  chk("R1 reload", v, 'hFFF);
        rd(A_WIN, v);  chk("R1 window", v, 'hFFF);
        rd(A_STAT, v); chk("R1 status", v, 0);
        chk("R1 request low", int'(wdt_req), 0);
    endtask

    task automatic t_lock();
        int v;
        do_reset();
        wr(A_RLD, 5);
        rd(A_RLD, v);  chk("R3 locked reload write", v, 'hFFF);
        rd(A_STAT, v); chk("R3 locked write no flag", v, 0);
        wr(A_KEY, K_OPEN);
        wr(A_RLD, 5);
        rd(A_RLD, v);  chk("R2 reload after open", v, 5);
        wr(A_WIN, 'h123);
        rd(A_WIN, v);  chk("R2 window after open", v, 'h123);
        wr(A_KEY, K_KICK);
        wr(A_RLD, 6);
        rd(A_RLD, v);  chk("R3 refresh key keeps lock open", v, 6);
        wr(A_KEY, 32'h1234);
        wr(A_RLD, 9);
        rd(A_RLD, v);  chk("R3 unknown key closes", v, 6);
        wr(A_KEY, K_OPEN);
        wr(A_KEY, K_SHUT);
        wr(A_DIV, 3);
        rd(A_DIV, v);  chk("R3 close key closes", v, 0);
    endtask

    task automatic t_pending();
        int v;
        do_reset();
        wr(A_KEY, K_OPEN);
        tick = 1'b0;
        wr(A_DIV, 3);
        rd(A_STAT, v); chk("R4 divider flag set", v, 1);
        repeat (5) @(negedge clk);
        rd(A_STAT, v); chk("R4 flag holds without tick", v, 1);
        tick = 1'b1;
        @(negedge clk);
        rd(A_STAT, v); chk("R4 flag after one tick", v, 1);
        @(negedge clk);
        rd(A_STAT, v); chk("R4 flag clear after two ticks", v, 0);
        rd(A_DIV, v);  chk("R2 divider readback", v, 3);
        wr(A_RLD, 7);
        rd(A_STAT, v); chk("R4 reload flag set", v, 2);
        @(negedge clk);
        rd(A_STAT, v); chk("R4 reload flag after one tick", v, 2);
        @(negedge clk);
        rd(A_STAT, v); chk("R4 reload flag clear", v, 0);
    endtask

    task automatic t_timeout();
        int n;
        do_reset();
        configure(0, 3);
        wr(A_KEY, K_RUN);
        wait_pulse(n); chk("R6 first timeout at (3+1)*4", n, 16);
        @(negedge clk);
        chk("R6 pulse lasts one cycle", int'(wdt_req), 0);
        wait_pulse(n); chk("R7 repeated timeout period", n, 15);
    endtask

    task automatic t_codes();
        int n;
        do_reset();
        configure(2, 1);
        wr(A_KEY, K_RUN);
        wait_pulse(n); chk("R6 code 2 divider 16", n, 32);
        do_reset();
        configure(7, 0);
        wr(A_KEY, K_RUN);
        wait_pulse(n); chk("R6 code 7 divider 256", n, 256);
    endtask

    task automatic t_update_use();
        int n;
        do_reset();
        configure(0, 3);
        wr(A_KEY, K_RUN);
        wr(A_RLD, 1);
        wr(A_KEY, K_KICK);
        wait_pulse(n); chk("R5 refresh uses old reload", n, 16);
        wait_pulse(n); chk("R5 new reload after flag clears", n, 8);
    endtask

    task automatic t_refresh();
        int n, seen;
        do_reset();
        configure(0, 3);
        wr(A_KEY, K_RUN);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            seen += int'(wdt_req);
        end
        chk("R8 no pulse before refresh", seen, 0);
        wr(A_KEY, K_KICK);
        wait_pulse(n); chk("R8 full period after refresh", n, 16);
    endtask

    task automatic t_sticky();
        int n;
        do_reset();
        configure(0, 3);
        wr(A_KEY, K_RUN);
        wr(A_KEY, K_SHUT);
        wr(A_KEY, 32'h1234);
        wait_pulse(n); chk("R9 still running after keys", n, 14);
    endtask

    task automatic t_window();
        int n, seen;
        do_reset();
        configure(0, 10);
        wr(A_WIN, 2);
        repeat (2) @(negedge clk);
        wr(A_KEY, K_RUN);
        wr(A_KEY, K_KICK);
        chk("R10 early refresh pulse", int'(wdt_req), 1);
        seen = 0;
        for (int i = 0; i < 34; i++) begin
            @(negedge clk);
            seen += int'(wdt_req);
        end
        chk("R10 no pulse while counting", seen, 0);
        wr(A_KEY, K_KICK);
        chk("R10 in-window refresh no pulse", int'(wdt_req), 0);
        wait_pulse(n); chk("R10 in-window refresh reloads", n, 44);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_pending();
        t_timeout();
        t_codes();
        t_update_use();
        t_refresh();
        t_sticky();
        t_window();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule